// File: doc/BRIEF.md
# Electronic Shutter Pulse Scheduler

This block decides when the substrate shutter pulse of an interline image sensor fires. Exposure is set as a whole number of lines. The frame rate does not change. The line sequencer supplies three single-cycle markers: a frame marker (asserted together with the line-start marker of line 0), a line-start marker (horizontal clocking begins), and a horizontal-end marker (horizontal clocking stops and the retrace interval opens). The block emits at most one fixed-width pulse per frame. That pulse always falls inside a horizontal retrace interval. The high-voltage driver is outside this block.

For an exposure of N lines, the pulse is placed in the retrace of line `LINES - N`. That is N lines before the readout pulse at the start of the next frame. Integration runs from the falling edge of the shutter pulse to that readout. Moving the pulse to a different retrace interval therefore changes the exposure in steps of whole lines.

The exposure and enable inputs are captured only at the frame marker, so any update takes effect at a frame boundary. The block measures the length of each retrace interval. If the previous retrace was too short to hold the gap and the pulse, the pulse for that frame is withheld and an error flag is raised. If horizontal clocking resumes while a pulse is still pending or high, the pulse is dropped at once and the error flag is raised.

Top module: `shutter_sched`

## Requirements
- R1: At most one pulse is issued per frame. It is issued only in the retrace of line index `LINES - N`, where N is the captured exposure and line 0 is the line that carries the frame marker. Each line-start without the frame marker advances the line index by one.
- R2: If horizontal-end is sampled high on clock edge t of the target line and the pulse is allowed, `shutterPulse` is high from edge t+GAP_CYC up to edge t+GAP_CYC+WIDTH_CYC, which is WIDTH_CYC cycles in total. A retrace of exactly GAP_CYC+WIDTH_CYC cycles is long enough.
- R3: `expLines` and `shutterEn` are captured only on a cycle with `frameStart` high. Changing them at any other time has no effect on the pulse until the next frame marker.
- R4: When the captured enable is 0, no pulse is issued during that frame.
- R5: An exposure value of 0 is treated as 1, so the pulse goes in line LINES-1. Any value of LINES or above is treated as LINES-1, so the pulse goes in line 1.
- R6: The retrace length of a line is the number of cycles from its horizontal-end to the next line-start. If the retrace of the line before the target line was shorter than GAP_CYC+WIDTH_CYC cycles, no pulse is issued that frame, and `shutterErr` rises one cycle after the target line's horizontal-end.
- R7: If line-start arrives before a pulse in progress has completed (during the gap or while the pulse is high), `shutterPulse` is low from the next cycle. `shutterErr` rises in that same cycle, and no further pulse is issued that frame.
- R8: `shutterErr` stays high until the next frame marker, which clears it. If an error event happens on the same edge as the frame marker, the error wins and the flag stays high.
- R9: While reset is asserted and after reset, `shutterPulse` and `shutterErr` are 0, and no pulse is issued before a frame marker captures an enable of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frameStart | input | 1 | Frame marker, asserted together with lineStart of line 0 |
| lineStart | input | 1 | Horizontal clocking begins for a new line |
| hEnd | input | 1 | Horizontal clocking has stopped; retrace begins |
| expLines | input | $clog2(LINES) | Exposure in lines, captured at frameStart |
| shutterEn | input | 1 | Shutter enable, captured at frameStart |
| shutterPulse | output | 1 | Shutter pulse request to the high-voltage driver |
| shutterErr | output | 1 | Pulse withheld or cut this frame |

## Verification
The assertions take the following for granted about the inputs:
- the markers are single-cycle pulses;
- `hEnd` never coincides with `lineStart` and occurs once per line;
- `frameStart` comes only together with a `lineStart`.

The bench builds every frame from exactly that pattern. Each line has a fixed active part ending in `hEnd`, followed by a chosen retrace length before the next `lineStart`. Random values are confined to the exposure, the enable, the retrace lengths and the junk written to the settings in mid-frame.

// File: rtl/shutter_pkg.sv
package shutter_pkg;

  // Strobes from the control half to the pulse datapath.
  typedef struct packed {
    logic arm;         // start the gap/pulse sequence in this retrace
    logic retraceEnd;  // horizontal clocking resumes on this edge
  } pulse_cmd_t;

  typedef enum logic [1:0] {
    PG_IDLE = 2'd0,
    PG_WAIT = 2'd1,
    PG_HIGH = 2'd2
  } pg_state_e;

endpackage

// File: rtl/shutter_ctrl.sv
module shutter_ctrl
  import shutter_pkg::*;
#(
  parameter int LINES     = 525,
  parameter int GAP_CYC   = 100,
  parameter int WIDTH_CYC = 500,
  parameter int EXP_W     = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frameStart,
  input  logic             lineStart,
  input  logic             hEnd,
  input  logic [EXP_W-1:0] expLines,
  input  logic             shutterEn,
  input  logic             cutEvt,
  output pulse_cmd_t       cmd,
  output logic             retraceOpen,
  output logic             shutterErr
);

  localparam int LW     = $clog2(LINES);
  localparam int BUDGET = GAP_CYC + WIDTH_CYC;
  localparam int RW     = $clog2(BUDGET + 1);

  logic [EXP_W-1:0] expShadow;
  logic             enShadow;
  logic [LW-1:0]    lineIdx;
  logic [LW-1:0]    targetLine;
  logic [RW-1:0]    retraceCnt;
  logic [RW-1:0]    lastRetrace;
  logic             inRetrace;
  logic             doneQ;
  logic             errQ;
  logic             isTarget;
  logic             budgetOk;
  logic             suppress;
  logic             errEvent;

  function automatic logic [EXP_W-1:0] clampExp(input logic [EXP_W-1:0] v);
    if (v == '0)             return EXP_W'(1);
    if (int'(v) >= LINES)    return EXP_W'(LINES - 1);
    return v;
  endfunction

  always_comb begin
    targetLine     = LW'(LINES - int'(expShadow));
    isTarget       = hEnd && enShadow && !doneQ && (lineIdx == targetLine);
    budgetOk       = (lastRetrace >= RW'(BUDGET));
    suppress       = isTarget && !budgetOk;
    cmd.arm        = isTarget && budgetOk;
    cmd.retraceEnd = lineStart;
    errEvent       = suppress || cutEvt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      expShadow   <= EXP_W'(1);
      enShadow    <= 1'b0;
      lineIdx     <= '0;
      retraceCnt  <= '0;
      lastRetrace <= '0;
      inRetrace   <= 1'b0;
      doneQ       <= 1'b0;
      errQ        <= 1'b0;
    end else begin
      if (frameStart) begin
        expShadow <= clampExp(expLines);
        enShadow  <= shutterEn;
      end

      if (frameStart)
        lineIdx <= '0;
      else if (lineStart && (lineIdx != LW'(LINES - 1)))
        lineIdx <= lineIdx + 1'b1;

      if (hEnd) begin
        inRetrace  <= 1'b1;
        retraceCnt <= RW'(1);
      end else if (lineStart) begin
        inRetrace   <= 1'b0;
        lastRetrace <= retraceCnt;
      end else if (inRetrace && (retraceCnt != RW'(BUDGET))) begin
        retraceCnt <= retraceCnt + 1'b1;
      end

      if (frameStart)
        doneQ <= 1'b0;
      else if (isTarget)
        doneQ <= 1'b1;

      errQ <= (errQ && !frameStart) || errEvent;
    end
  end

  assign retraceOpen = inRetrace;
  assign shutterErr  = errQ;

  // R3
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frameStart |=> ($stable(expShadow) && $stable(enShadow)));

  // R8
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frameStart && !errEvent) |=> !shutterErr);

  // R6
  suppress_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suppress |=> shutterErr);

endmodule

// File: rtl/shutter_pulse_gen.sv
module shutter_pulse_gen
  import shutter_pkg::*;
#(
  parameter int GAP_CYC   = 100,
  parameter int WIDTH_CYC = 500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  pulse_cmd_t cmd,
  output logic       pulseQ,
  output logic       cutEvt
);

  localparam int MAXC = (GAP_CYC > WIDTH_CYC) ? GAP_CYC : WIDTH_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  pg_state_e   state;
  logic [CW-1:0] cnt;
  logic [CW:0]   highRun;

  always_comb begin
    cutEvt = cmd.retraceEnd &&
             ((state == PG_WAIT) ||
              ((state == PG_HIGH) && (cnt != CW'(WIDTH_CYC))));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= PG_IDLE;
      cnt    <= '0;
      pulseQ <= 1'b0;
    end else begin
      case (state)
        PG_IDLE: begin
          if (cmd.arm) begin
            state <= PG_WAIT;
            cnt   <= CW'(1);
          end
        end
        PG_WAIT: begin
          if (cmd.retraceEnd) begin
            state <= PG_IDLE;
          end else if (cnt == CW'(GAP_CYC)) begin
            state  <= PG_HIGH;
            cnt    <= CW'(1);
            pulseQ <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PG_HIGH: begin
          if ((cnt == CW'(WIDTH_CYC)) || cmd.retraceEnd) begin
            state  <= PG_IDLE;
            pulseQ <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= PG_IDLE;
      endcase
    end
  end

  // Length of the current high run, kept for the width check.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      highRun <= '0;
    else if (!pulseQ)
      highRun <= '0;
    else if (highRun != '1)
      highRun <= highRun + 1'b1;
  end

  // R7
  resume_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.retraceEnd |=> !pulseQ);

  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulseQ) |-> ((highRun == (CW+1)'(WIDTH_CYC)) || $past(cutEvt)));

  // R7
  cut_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cutEvt |=> !pulseQ);

endmodule

// File: rtl/shutter_sched.sv
module shutter_sched
  import shutter_pkg::*;
#(
  parameter int LINES     = 525,
  parameter int GAP_CYC   = 100,
  parameter int WIDTH_CYC = 500,
  localparam int EXP_W    = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frameStart,
  input  logic             lineStart,
  input  logic             hEnd,
  input  logic [EXP_W-1:0] expLines,
  input  logic             shutterEn,
  output logic             shutterPulse,
  output logic             shutterErr
);

  pulse_cmd_t cmd;
  logic       cutEvt;
  logic       retraceOpen;
  logic       prevPulse;
  logic [1:0] riseCnt;

  shutter_ctrl #(
    .LINES(LINES), .GAP_CYC(GAP_CYC), .WIDTH_CYC(WIDTH_CYC), .EXP_W(EXP_W)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n), .frameStart(frameStart), .lineStart(lineStart),
    .hEnd(hEnd), .expLines(expLines), .shutterEn(shutterEn), .cutEvt(cutEvt),
    .cmd(cmd), .retraceOpen(retraceOpen), .shutterErr(shutterErr)
  );

  shutter_pulse_gen #(
    .GAP_CYC(GAP_CYC), .WIDTH_CYC(WIDTH_CYC)
  ) i_pulse (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .pulseQ(shutterPulse), .cutEvt(cutEvt)
  );

  // Count pulse starts per frame for the one-per-frame check.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevPulse <= 1'b0;
      riseCnt   <= '0;
    end else begin
      prevPulse <= shutterPulse;
      if (frameStart)
        riseCnt <= '0;
      else if (shutterPulse && !prevPulse && (riseCnt != 2'd3))
        riseCnt <= riseCnt + 1'b1;
    end
  end

  // R1
  in_retrace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutterPulse |-> retraceOpen);

  // R1
  one_per_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shutterPulse && !prevPulse) |-> (riseCnt == 2'd0));

endmodule

// File: tb/test_shutter_sched.sv
module test_shutter_sched;

  localparam int LINES  = 12;
  localparam int GAP    = 3;
  localparam int WID    = 4;
  localparam int BUDGET = GAP + WID;
  localparam int ACT    = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frameStart = 1'b0;
  logic       lineStart = 1'b0;
  logic       hEnd = 1'b0;
  logic [3:0] expLines = 4'd0;
  logic       shutterEn = 1'b0;
  logic       shutterPulse;
  logic       shutterErr;

  int total = 0;
  int bad = 0;
  bit expErr = 1'b0;
  bit carryCut = 1'b0;

  always #5 clk = ~clk;

  shutter_sched #(.LINES(LINES), .GAP_CYC(GAP), .WIDTH_CYC(WID)) i_shutter_sched (
    .clk(clk), .rst_n(rst_n), .frameStart(frameStart), .lineStart(lineStart),
    .hEnd(hEnd), .expLines(expLines), .shutterEn(shutterEn),
    .shutterPulse(shutterPulse), .shutterErr(shutterErr)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int clampN(input int n);
    if (n == 0) return 1;
    if (n >= LINES) return LINES - 1;
    return n;
  endfunction

  // One frame of LINES lines; every line has retrace rDef except oddLine.
  task automatic runFrame(input int n, input bit en, input int rDef,
                          input int oddLine, input int oddR, input string tag);
    int tgt = LINES - clampN(n);
    int hiCnt = 0;
    int expHi = 0;
    for (int ln = 0; ln < LINES; ln++) begin
      int r = (ln == oddLine) ? oddR : rDef;
      int prevR = (ln == 0) ? 0 : (((ln - 1) == oddLine) ? oddR : rDef);
      bit isT = en && (ln == tgt);
      bit ok = (prevR >= BUDGET);
      if (isT && ok) expHi = (r - GAP < WID) ? ((r - GAP > 0) ? r - GAP : 0) : WID;
      for (int c = 0; c < ACT + r; c++) begin
        bit ep;
        frameStart = (ln == 0) && (c == 0);
        lineStart  = (c == 0);
        hEnd       = (c == ACT);
        if (ln == 0 && c == 0) begin
          expLines  = 4'(n);
          shutterEn = en;
        end else if ($urandom % 4 == 0) begin
          expLines  = 4'($urandom);
          shutterEn = 1'($urandom);
        end
        @(negedge clk);
        if (c == 0) begin
          if (ln == 0) expErr = carryCut;
          else expErr = expErr | carryCut;
          carryCut = 1'b0;
        end
        if (c == ACT && isT && !ok) expErr = 1'b1;
        ep = isT && ok && (c >= ACT + GAP) && (c <= ACT + GAP + WID - 1);
        if (shutterPulse) hiCnt++;
        check(shutterPulse === ep, tag, $sformatf("pulse line %0d cyc %0d", ln, c),
              int'(shutterPulse), int'(ep));
        check(shutterErr === expErr, tag, $sformatf("err line %0d cyc %0d", ln, c),
              int'(shutterErr), int'(expErr));
      end
      if (isT && ok && r < BUDGET) carryCut = 1'b1;
    end
    check(hiCnt == expHi, tag, "pulse cycles in frame", hiCnt, expHi);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R9 during and after reset
    check(shutterPulse === 1'b0, "R9", "pulse in reset", int'(shutterPulse), 0);
    check(shutterErr === 1'b0, "R9", "err in reset", int'(shutterErr), 0);
    rst_n = 1'b1;
    hEnd = 1'b1;
    @(negedge clk);
    hEnd = 1'b0;
    repeat (12) @(negedge clk);
    check(shutterPulse === 1'b0, "R9", "pulse before frame", int'(shutterPulse), 0);
    check(shutterErr === 1'b0, "R9", "err before frame", int'(shutterErr), 0);

    runFrame(3, 1'b1, 10, -1, 0, "R1");
    runFrame(1, 1'b1, 10, -1, 0, "R2");
    runFrame(11, 1'b1, 9, -1, 0, "R1");
    runFrame(0, 1'b1, 10, -1, 0, "R5");
    runFrame(15, 1'b1, 10, -1, 0, "R5");
    runFrame(12, 1'b1, 8, -1, 0, "R5");
    runFrame(4, 1'b0, 10, -1, 0, "R4");
    runFrame(5, 1'b1, 11, -1, 0, "R3");
    runFrame(4, 1'b1, 10, 7, 5, "R6");
    runFrame(4, 1'b1, 10, 7, 6, "R6");
    runFrame(4, 1'b1, 10, -1, 0, "R8");
    runFrame(4, 1'b1, 10, 8, 5, "R7");
    runFrame(4, 1'b1, 10, 8, 2, "R7");
    runFrame(4, 1'b1, 10, 8, 3, "R7");
    runFrame(4, 1'b1, 10, 8, 7, "R2");
    runFrame(1, 1'b1, 10, 11, 5, "R7");
    runFrame(6, 1'b1, 10, -1, 0, "R8");
    runFrame(6, 1'b1, 10, -1, 0, "R8");

    for (int f = 0; f < 30; f++) begin
      int n = int'($urandom % 16);
      bit en = 1'($urandom % 4 != 0);
      int rDef = 7 + int'($urandom % 6);
      int odd = int'($urandom % LINES);
      int oddR = 1 + int'($urandom % 12);
      runFrame(n, en, rDef, odd, oddR, "R1");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule